// File: doc/BRIEF.md
# Wake-up Event Router

This block gathers up to twenty single-bit event lines from peripherals and wake pins and turns them into a single wake/interrupt request. Every line first crosses into the block's clock domain through a two-stage synchronizer. A per-line detector then looks for either a level or an edge, and a per-line polarity bit picks which level or direction counts as active. Each detected event is latched in a status register. The status register is masked by an enable register, and the OR of the surviving bits drives a registered wake output.

Software uses a simple strobed register bus: a write strobe, a read strobe, a 3-bit word index and 32-bit data. Polarity and mode are ordinary read/write registers. Enable and status are read-only. They change only through four write-only ports, which set or clear the bits where a 1 is written. Lines 17 and 18 of the 20-bit event field are not implemented. Status leaves reset with every implemented bit set, so software clears what it does not want before it enables wake.

Word index map: 0 polarity, 1 mode, 2 enable (read-only), 3 status (read-only), 4 enable-set, 5 enable-clear, 6 status-set, 7 status-clear. Event line n maps to data bit n in every register.

Top module: `wake_event_router`

## Requirements
- R1: Bits 17 and 18 and all bits from 20 upward read as zero in every register and ignore writes. A status or enable set written to them has no effect, and activity on event lines 17 and 18 is never latched.
- R2: After reset, status reads 0x0009FFFF, enable, polarity and mode read 0, and wake is 0.
- R3: Polarity (index 0) and mode (index 1) are read/write. The detector uses these encodings: mode 0 with polarity 0 detects a low level; mode 0 with polarity 1 detects a high level; mode 1 with polarity 0 detects a falling edge; mode 1 with polarity 1 detects a rising edge.
- R4: Writing to index 4 sets each enable bit where the data holds a 1. Writing to index 5 clears each enable bit where the data holds a 1. Zero bits leave enable unchanged.
- R5: Writing to index 6 sets each status bit where the data holds a 1. Writing to index 7 clears each status bit where the data holds a 1.
- R6: Indices 4 to 7 read back as zero.
- R7: In level mode, an input that is active at clock edge k sets its status bit at edge k+2.
- R8: In edge mode, only a transition into the active level sets status, with the same k+2 latency. A line held steady at the active level does not set status again after a clear.
- R9: When a detection and a status-clear reach the same bit in the same cycle, the bit stays set. A level-mode bit cleared while its input is still active therefore reads back as set.
- R10: Wake is the OR over all bits of status AND enable, registered once. It changes one clock after the status or enable change that causes it.
- R11: Read data is registered: a read strobe at edge k presents the addressed register on rd_data after edge k, and rd_data holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_in | input | 20 | Raw asynchronous event lines, one per source bit |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rd_en | input | 1 | Read strobe, one cycle per read |
| addr | input | 3 | Register word index |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| wake | output | 1 | Registered combined wake/interrupt request |

## Verification
The synchronizer, detector, status latch and wake flop form a fixed chain. A wrong stage count or a wrong detector state therefore shows on `wake` one or more cycles away from the expected edge. The bench checks `wake` on the exact cycle before and after it should rise. A status bit that re-arms when it should not, or that fails to stick when a clear races an active input, shows on the first status read after the clear. A bad enable or an unimplemented bit that has become live shows either on the next read or on `wake` one cycle after the write that should or should not have affected it.

// File: rtl/wer_pkg.sv
package wer_pkg;
  // Word index of each register on the strobed bus.
  typedef enum logic [2:0] {
    IDX_POL    = 3'd0,
    IDX_MODE   = 3'd1,
    IDX_EN     = 3'd2,
    IDX_ST     = 3'd3,
    IDX_EN_SET = 3'd4,
    IDX_EN_CLR = 3'd5,
    IDX_ST_SET = 3'd6,
    IDX_ST_CLR = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/wer_sync.sv
module wer_sync #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d;
      stage2_q <= stage1_q;
    end
  end

  assign q = stage2_q;
endmodule

// File: rtl/wer_detect.sv
module wer_detect #(
  parameter int W = 20
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sig,
  input  logic [W-1:0] mode,
  input  logic [W-1:0] pol,
  output logic [W-1:0] hit
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= sig;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic at_active;
    assign at_active = (sig[i] == pol[i]);
    // mode 1: a change that lands on the active level; mode 0: the level
    assign hit[i] = mode[i] ? (at_active & (sig[i] ^ prev_q[i])) : at_active;
  end
endmodule

// File: rtl/wer_regfile.sv
module wer_regfile
  import wer_pkg::*;
#(
  parameter int          W      = 20,
  parameter int          DATA_W = 32,
  parameter logic [W-1:0] IMPL  = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [W-1:0]      hit,
  output logic [W-1:0]      pol_q,
  output logic [W-1:0]      mode_q,
  output logic [W-1:0]      en_q,
  output logic [W-1:0]      st_q,
  output logic [DATA_W-1:0] rd_data
);
  localparam int PAD = DATA_W - W;

  reg_idx_e      idx;
  logic [W-1:0]  wd;
  logic [W-1:0]  hit_m;
  logic          unused_wr_hi;
  logic [W-1:0]  rd_mux;
  logic [DATA_W-1:0] rd_q;

  assign idx          = reg_idx_e'(addr);
  assign wd           = wr_data[W-1:0] & IMPL;
  assign hit_m        = hit & IMPL;
  assign unused_wr_hi = ^wr_data[DATA_W-1:W];

  function automatic logic sel(input reg_idx_e cur, input reg_idx_e want, input logic stb);
    return stb && (cur == want);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pol_q  <= '0;
      mode_q <= '0;
      en_q   <= '0;
      st_q   <= IMPL;
    end else begin
      if (sel(idx, IDX_POL, wr_en))  pol_q  <= wd;
      if (sel(idx, IDX_MODE, wr_en)) mode_q <= wd;
      if (sel(idx, IDX_EN_SET, wr_en))      en_q <= en_q | wd;
      else if (sel(idx, IDX_EN_CLR, wr_en)) en_q <= en_q & ~wd;
      // detection is ORed in after the clear, so it wins a same-cycle race
      if (sel(idx, IDX_ST_SET, wr_en))      st_q <= st_q | wd | hit_m;
      else if (sel(idx, IDX_ST_CLR, wr_en)) st_q <= (st_q & ~wd) | hit_m;
      else                                  st_q <= st_q | hit_m;
    end
  end

  always_comb begin
    unique case (idx)
      IDX_POL:  rd_mux = pol_q;
      IDX_MODE: rd_mux = mode_q;
      IDX_EN:   rd_mux = en_q;
      IDX_ST:   rd_mux = st_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= {{PAD{1'b0}}, rd_mux};
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/wake_event_router.sv
module wake_event_router #(
  parameter int           N_SRC  = 20,
  parameter int           DATA_W = 32,
  parameter logic [N_SRC-1:0] IMPL_MASK = 20'h9FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  ev_in,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [2:0]        addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              wake
);
  logic [N_SRC-1:0] ev_sync;
  logic [N_SRC-1:0] hit;
  logic [N_SRC-1:0] pol_q;
  logic [N_SRC-1:0] mode_q;
  logic [N_SRC-1:0] en_q;
  logic [N_SRC-1:0] st_q;
  logic             wake_q;

  wer_sync #(.W(N_SRC)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ev_in), .q(ev_sync)
  );

  wer_detect #(.W(N_SRC)) u_det (
    .clk(clk), .rst_n(rst_n), .sig(ev_sync), .mode(mode_q), .pol(pol_q), .hit(hit)
  );

  wer_regfile #(.W(N_SRC), .DATA_W(DATA_W), .IMPL(IMPL_MASK)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .hit(hit), .pol_q(pol_q), .mode_q(mode_q),
    .en_q(en_q), .st_q(st_q), .rd_data(rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wake_q <= 1'b0;
    else        wake_q <= |(st_q & en_q);
  end

  assign wake = wake_q;
endmodule

// File: rtl/wer_chk.sv
module wer_chk #(
  parameter int W = 20,
  parameter int DATA_W = 32,
  parameter logic [W-1:0] IMPL = 20'h9FFFF
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [2:0]        addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              wake,
  input logic [W-1:0]      en_q,
  input logic [W-1:0]      st_q,
  input logic [W-1:0]      hit
);
  localparam logic [DATA_W-1:0] LIVE = {{(DATA_W-W){1'b0}}, IMPL};

  assert_dead_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~LIVE) == '0);

  assert_en_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd4) |=> ((en_q & $past(wr_data[W-1:0]) & IMPL) == ($past(wr_data[W-1:0]) & IMPL)));

  assert_en_clr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd5) |=> ((en_q & $past(wr_data[W-1:0])) == '0));

  assert_st_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 3'd6) |=> ((st_q & $past(wr_data[W-1:0]) & IMPL) == ($past(wr_data[W-1:0]) & IMPL)));

  assert_wo_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr[2]) |=> (rd_data == '0));

  assert_hw_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((st_q & $past(hit & IMPL)) == $past(hit & IMPL)));

  assert_wake_reg_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (wake == $past(|(st_q & en_q))));

  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

bind wake_event_router wer_chk #(.W(N_SRC), .DATA_W(DATA_W), .IMPL(IMPL_MASK)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wr_data(wr_data), .rd_data(rd_data), .wake(wake),
  .en_q(en_q), .st_q(st_q), .hit(hit)
);

// File: tb/wake_event_router_test.sv
module wake_event_router_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] ev_in = '1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        wake;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wake_event_router uut (
    .clk(clk), .rst_n(rst_n), .ev_in(ev_in), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .wake(wake)
  );

  // entry: {req[3:0], is_read, index[2:0], data/expected[31:0]}
  localparam int NV = 22;
  localparam logic [39:0] VEC [NV] = '{
    {4'd2,  1'b1, 3'd3, 32'h0009FFFF}, // R2 status reset
    {4'd2,  1'b1, 3'd2, 32'h00000000}, // R2 enable reset
    {4'd2,  1'b1, 3'd0, 32'h00000000}, // R2 polarity reset
    {4'd2,  1'b1, 3'd1, 32'h00000000}, // R2 mode reset
    {4'd4,  1'b0, 3'd4, 32'hFFFFFFFF}, // R4 set all enables
    {4'd1,  1'b1, 3'd2, 32'h0009FFFF}, // R1 dead bits stay zero
    {4'd4,  1'b0, 3'd5, 32'h00000005},
    {4'd4,  1'b1, 3'd2, 32'h0009FFFA}, // R4 clear bits 0 and 2
    {4'd4,  1'b0, 3'd4, 32'h00000000},
    {4'd4,  1'b1, 3'd2, 32'h0009FFFA}, // R4 zero write no effect
    {4'd4,  1'b0, 3'd5, 32'hFFFFFFFF},
    {4'd4,  1'b1, 3'd2, 32'h00000000},
    {4'd5,  1'b0, 3'd7, 32'hFFFFFFFF},
    {4'd5,  1'b1, 3'd3, 32'h00000000}, // R5 clear all status
    {4'd5,  1'b0, 3'd6, 32'h00080001},
    {4'd5,  1'b1, 3'd3, 32'h00080001}, // R5 set status 0 and 19
    {4'd6,  1'b1, 3'd6, 32'h00000000}, // R6 write-only reads zero
    {4'd6,  1'b1, 3'd5, 32'h00000000}, // R6
    {4'd3,  1'b0, 3'd1, 32'hFFFFFFFF},
    {4'd3,  1'b1, 3'd1, 32'h0009FFFF}, // R3 mode read/write
    {4'd3,  1'b0, 3'd1, 32'h00000000},
    {4'd11, 1'b1, 3'd1, 32'h00000000}  // R11 read after write
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(3);
    chk("R2 wake after reset", {31'b0, wake}, 32'h0);
    chk("R2 rd_data after reset", rd_data, 32'h0);
    rst_n = 1'b1;
    idle(4);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][35]) begin
        rd(VEC[i][34:32], v);
        chk($sformatf("R%0d table step %0d", VEC[i][39:36], i), v, VEC[i][31:0]);
      end else begin
        wr(VEC[i][34:32], VEC[i][31:0]);
      end
    end

    // R7 high level on bit 3 and its latency to wake (R10)
    ev_in[3] = 1'b0;
    wr(3'd0, 32'h8);
    wr(3'd4, 32'h8);
    wr(3'd7, 32'hFFFFFFFF);
    idle(1);
    chk("R7 status clear before level", {31'b0, wake}, 32'h0);
    @(negedge clk) ev_in[3] = 1'b1;
    idle(3);
    chk("R10 wake not before edge k+3", {31'b0, wake}, 32'h0);
    idle(1);
    chk("R7 wake after high level", {31'b0, wake}, 32'h1);
    // R9 clear while still active stays set
    wr(3'd7, 32'h8);
    rd(3'd3, v);
    chk("R9 level bit survives clear", v, 32'h8);
    ev_in[3] = 1'b0;
    idle(3);
    wr(3'd7, 32'h8);
    rd(3'd3, v);
    chk("R7 cleared after input inactive", v, 32'h0);
    chk("R10 wake drops after clear", {31'b0, wake}, 32'h0);

    // R8 rising edge on bit 5
    wr(3'd1, 32'h20);
    ev_in[5] = 1'b0;
    wr(3'd0, 32'h28);
    idle(3);
    wr(3'd7, 32'hFFFFFFFF);
    rd(3'd3, v);
    chk("R8 no edge yet", v, 32'h0);
    ev_in[5] = 1'b1;
    idle(4);
    rd(3'd3, v);
    chk("R8 rising edge latched", v, 32'h20);
    wr(3'd7, 32'h20);
    idle(2);
    rd(3'd3, v);
    chk("R8 steady high does not re-set", v, 32'h0);

    // R3 falling edge on bit 0
    wr(3'd1, 32'h21);
    ev_in[0] = 1'b0;
    idle(4);
    rd(3'd3, v);
    chk("R3 falling edge latched", v, 32'h1);
    wr(3'd7, 32'h1);
    idle(2);
    rd(3'd3, v);
    chk("R8 steady low does not re-set", v, 32'h0);

    // R3 default encoding: low level on bit 19
    ev_in[19] = 1'b0;
    idle(4);
    rd(3'd3, v);
    chk("R3 low level on bit 19", v, 32'h00080000);
    ev_in[19] = 1'b1;
    idle(3);
    wr(3'd7, 32'h00080000);

    // R1 unimplemented bits 17 and 18
    ev_in[17] = 1'b0;
    ev_in[18] = 1'b0;
    wr(3'd6, 32'h00060000);
    idle(3);
    rd(3'd3, v);
    chk("R1 status bits 17/18 stay zero", v, 32'h0);
    wr(3'd4, 32'h00040000);
    rd(3'd2, v);
    chk("R1 enable bit 18 ignored", v, 32'h8);

    // R10 wake masked by enable
    wr(3'd5, 32'h8);
    wr(3'd6, 32'h4);
    idle(1);
    chk("R10 wake masked", {31'b0, wake}, 32'h0);
    wr(3'd4, 32'h4);
    chk("R10 wake not same cycle as enable", {31'b0, wake}, 32'h0);
    idle(1);
    chk("R10 wake one cycle after enable", {31'b0, wake}, 32'h1);

    // R11 rd_data holds between reads
    rd(3'd2, v);
    idle(3);
    chk("R11 rd_data held", rd_data, 32'h4);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule